// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

This block sits between a user port and a small on-chip flash array. The array takes one of three active-low command strobes (read, write, erase), an address bus, a write-data bus, and returns read data with an active-low busy line. One request on the user port becomes one complete strobe sequence. The sequence keeps the strobe low for a legal width and watches busy respond within its deadline. It holds the buses steady long enough, waits for the array to finish, and then reports completion.

All timing limits are given in nanoseconds. They are converted to clock cycles from a clock-period parameter: lower limits are rounded up and upper limits are rounded down. A state machine runs the sequence.

- IDLE accepts a request.
- PULSE drives the strobe low.
- GUARD keeps the buses held after an early, failed release.
- DRAIN waits for busy to return high.
- DONE emits the one-cycle completion pulse.

The transitions are:

- IDLE→PULSE on a valid request with a legal operation code.
- PULSE→DRAIN when the minimum width has elapsed and busy has been seen low, or when the maximum width is reached.
- PULSE→GUARD, or directly to DONE if the hold time is already met, on a busy-deadline timeout.
- GUARD→DONE when the hold time is met.
- DRAIN→DONE when busy is sampled high and the hold time is met.
- DONE→IDLE always.

Top module: `flash_cmd_seq`

## Requirements
- R1: Out of reset, all three strobes are high, `ready` is 1, `done` is 0, `err` is 0, and `rdata` is 0.
- R2: In IDLE, `req_valid` with `req_op` 0 (read), 1 (write) or 2 (erase) drives exactly that strobe low from the next cycle. The pairing is read→`fl_read_n`, write→`fl_write_n`, erase→`fl_erase_n`. Code 3 is ignored, and at most one strobe is ever low.
- R3: When busy is seen low in time, the strobe stays low for exactly max(MIN, cycle of first busy-low sample) cycles, and never for MAX cycles or more.
- R4: If busy has not been sampled low by the DL-th strobe-low cycle, the strobe is released after exactly DL cycles and `err` is set.
- R5: `fl_addr` and `fl_wdata` take the request values at acceptance. They stay unchanged for at least HOLD cycles after the strobe falls, and `done` cannot come before that.
- R6: After release, `done` pulses for one cycle, in the cycle after the edge at which busy is sampled high (and HOLD is met).
- R7: A read loads `rdata` with `fl_rdata` as sampled on the edge that ends DRAIN. Writes, erases and timed-out reads leave `rdata` unchanged.
- R8: `ready` is high only in IDLE. Requests presented while it is low are ignored.
- R9: `err` is sticky until reset, and later operations still run normally.
- R10: With a 35 ns clock and limits of 600/3000/300/600 ns, the cycle counts are MIN=18, MAX=85, DL=8 and HOLD=18.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe from user port |
| req_op | input | 2 | 0 read, 1 write, 2 erase, 3 none |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Request write data |
| ready | output | 1 | High when a request can be accepted |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DW | Last captured read data |
| err | output | 1 | Sticky busy-deadline error |
| fl_read_n | output | 1 | Active-low read strobe |
| fl_write_n | output | 1 | Active-low write strobe |
| fl_erase_n | output | 1 | Active-low erase strobe |
| fl_addr | output | AW | Address bus to the array |
| fl_wdata | output | DW | Write data bus to the array |
| fl_rdata | input | DW | Read data from the array |
| fl_busy_n | input | 1 | Active-low busy from the array |

## Verification
The hardest cases to reach are the deadline boundary and the GUARD state. In the first, busy falls on exactly the DL-th strobe-low cycle. In the second, a timed-out strobe has been released but the buses must still be held. The bench's array model takes a per-operation busy latency in cycles, so one run can set it to DL (accepted), to DL+1 (timeout), or to never (timeout, then GUARD until HOLD). The model also drives a poison value on `fl_rdata` while busy is low. A read captured one edge early is therefore exposed, and extra requests injected mid-sequence test that they are ignored.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_ERASE = 2'd2,
        OP_NONE  = 2'd3
    } fcs_op_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_PULSE = 3'd1,
        ST_GUARD = 3'd2,
        ST_DRAIN = 3'd3,
        ST_DONE  = 3'd4
    } fcs_state_e;

    localparam int unsigned NUM_STROBES = 3;

    // Lower limits: round up so the limit is always honoured.
    function automatic int unsigned ns_to_cyc_up(input int unsigned ns, input int unsigned per);
        return (ns + per - 1) / per;
    endfunction

    // Upper limits: round down so the limit is never exceeded.
    function automatic int unsigned ns_to_cyc_down(input int unsigned ns, input int unsigned per);
        return ns / per;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/fcs_req_latch.sv
module fcs_req_latch
    import fcs_pkg::*;
#(
    parameter int unsigned AW = 8,
    parameter int unsigned DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  fcs_op_e       op_in,
    input  logic [AW-1:0] addr_in,
    input  logic [DW-1:0] wdata_in,
    output fcs_op_e       op_q,
    output logic [AW-1:0] addr_q,
    output logic [DW-1:0] wdata_q
);

    // Values are loaded only on acceptance and held until the next one,
    // which keeps both buses still across strobe and hold window.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q    <= OP_NONE;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (load) begin
            op_q    <= op_in;
            addr_q  <= addr_in;
            wdata_q <= wdata_in;
        end
    end

endmodule

// File: rtl/fcs_window_cnt.sv
module fcs_window_cnt #(
    parameter int unsigned CW       = 8,
    parameter int unsigned MIN_CYC  = 18,
    parameter int unsigned MAX_CYC  = 85,
    parameter int unsigned DL_CYC   = 8,
    parameter int unsigned HOLD_CYC = 18
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    input  logic busy_low,
    output logic seen_now,
    output logic min_met,
    output logic max_hit,
    output logic dl_hit,
    output logic hold_met
);

    localparam int unsigned NW = CW + 1;

    logic [CW-1:0] cnt_q;
    logic          seen_q;
    logic [NW-1:0] n_ext;

    // n_ext is the number of elapsed cycles once the current edge closes.
    assign n_ext    = {1'b0, cnt_q} + NW'(1);
    assign seen_now = seen_q | busy_low;
    assign min_met  = n_ext >= NW'(MIN_CYC);
    assign max_hit  = n_ext >= NW'(MAX_CYC);
    assign dl_hit   = n_ext >= NW'(DL_CYC);
    assign hold_met = n_ext >= NW'(HOLD_CYC);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            seen_q <= 1'b0;
        end else if (clear) begin
            cnt_q  <= '0;
            seen_q <= 1'b0;
        end else if (run) begin
            if (cnt_q != {CW{1'b1}}) begin
                cnt_q <= cnt_q + CW'(1);
            end
            if (busy_low) begin
                seen_q <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/fcs_strobe_drive.sv
module fcs_strobe_drive
    import fcs_pkg::*;
#(
    parameter int unsigned NS = NUM_STROBES
) (
    input  logic          active,
    input  logic [1:0]    op,
    output logic [NS-1:0] strobe_n
);

    // One active-low line per operation code; index equals the code.
    for (genvar g = 0; g < NS; g++) begin : g_strobe
        assign strobe_n[g] = !(active && (op == 2'(g)));
    end

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import fcs_pkg::*;
#(
    parameter int unsigned CLK_NS         = 35,
    parameter int unsigned AW             = 8,
    parameter int unsigned DW             = 16,
    parameter int unsigned T_PULSE_MIN_NS = 600,
    parameter int unsigned T_PULSE_MAX_NS = 3000,
    parameter int unsigned T_BUSY_DL_NS   = 300,
    parameter int unsigned T_BUS_HOLD_NS  = 600
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [1:0]    req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          ready,
    output logic          done,
    output logic [DW-1:0] rdata,
    output logic          err,
    output logic          fl_read_n,
    output logic          fl_write_n,
    output logic          fl_erase_n,
    output logic [AW-1:0] fl_addr,
    output logic [DW-1:0] fl_wdata,
    input  logic [DW-1:0] fl_rdata,
    input  logic          fl_busy_n
);

    localparam int unsigned MIN_CYC  = ns_to_cyc_up(T_PULSE_MIN_NS, CLK_NS);
    localparam int unsigned MAX_CYC  = ns_to_cyc_down(T_PULSE_MAX_NS, CLK_NS);
    localparam int unsigned DL_CYC   = ns_to_cyc_down(T_BUSY_DL_NS, CLK_NS);
    localparam int unsigned HOLD_CYC = ns_to_cyc_up(T_BUS_HOLD_NS, CLK_NS);
    localparam int unsigned TOP_CYC  = max2(max2(MAX_CYC, HOLD_CYC), max2(MIN_CYC, DL_CYC));
    localparam int unsigned CW       = $clog2(TOP_CYC + 2);

    fcs_state_e state_q, state_d;

    fcs_op_e              op_q;
    logic [NUM_STROBES-1:0] strobe_n;

    logic accept;
    logic win_run;
    logic sample_busy;
    logic seen_now, min_met, max_hit, dl_hit, hold_met;
    logic timeout;
    logic cap_rd;
    logic pulse_on;

    logic          err_q;
    logic [DW-1:0] rdata_q;

    // ---------------------------------------------------------------
    // Sub-blocks
    // ---------------------------------------------------------------
    fcs_req_latch #(
        .AW (AW),
        .DW (DW)
    ) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .op_in    (fcs_op_e'(req_op)),
        .addr_in  (req_addr),
        .wdata_in (req_wdata),
        .op_q     (op_q),
        .addr_q   (fl_addr),
        .wdata_q  (fl_wdata)
    );

    fcs_window_cnt #(
        .CW       (CW),
        .MIN_CYC  (MIN_CYC),
        .MAX_CYC  (MAX_CYC),
        .DL_CYC   (DL_CYC),
        .HOLD_CYC (HOLD_CYC)
    ) u_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (accept),
        .run      (win_run),
        .busy_low (sample_busy),
        .seen_now (seen_now),
        .min_met  (min_met),
        .max_hit  (max_hit),
        .dl_hit   (dl_hit),
        .hold_met (hold_met)
    );

    fcs_strobe_drive #(
        .NS (NUM_STROBES)
    ) u_strobe (
        .active   (pulse_on),
        .op       (op_q),
        .strobe_n (strobe_n)
    );

    assign fl_read_n  = strobe_n[OP_READ];
    assign fl_write_n = strobe_n[OP_WRITE];
    assign fl_erase_n = strobe_n[OP_ERASE];

    // ---------------------------------------------------------------
    // State register
    // ---------------------------------------------------------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------------------------------------------------------
    // Transitions
    // ---------------------------------------------------------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid && (req_op != OP_NONE)) begin
                    state_d = ST_PULSE;
                end
            end
            ST_PULSE: begin
                if (!seen_now && dl_hit) begin
                    state_d = hold_met ? ST_DONE : ST_GUARD;
                end else if (seen_now && min_met) begin
                    state_d = ST_DRAIN;
                end else if (max_hit) begin
                    state_d = ST_DRAIN;
                end
            end
            ST_GUARD: begin
                if (hold_met) begin
                    state_d = ST_DONE;
                end
            end
            ST_DRAIN: begin
                if (fl_busy_n && hold_met) begin
                    state_d = ST_DONE;
                end
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // ---------------------------------------------------------------
    // Outputs and control strobes
    // ---------------------------------------------------------------
    always_comb begin
        ready       = 1'b0;
        done        = 1'b0;
        pulse_on    = 1'b0;
        accept      = 1'b0;
        win_run     = 1'b0;
        sample_busy = 1'b0;
        timeout     = 1'b0;
        cap_rd      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                ready  = 1'b1;
                accept = req_valid && (req_op != OP_NONE);
            end
            ST_PULSE: begin
                pulse_on    = 1'b1;
                win_run     = 1'b1;
                sample_busy = !fl_busy_n;
                timeout     = !seen_now && dl_hit;
            end
            ST_GUARD: begin
                win_run = 1'b1;
            end
            ST_DRAIN: begin
                win_run = 1'b1;
                cap_rd  = fl_busy_n && hold_met && (op_q == OP_READ);
            end
            ST_DONE: begin
                done = 1'b1;
            end
            default: begin
                ready = 1'b0;
            end
        endcase
    end

    // ---------------------------------------------------------------
    // Sticky error and read capture
    // ---------------------------------------------------------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q   <= 1'b0;
            rdata_q <= '0;
        end else begin
            if (timeout) begin
                err_q <= 1'b1;
            end
            if (cap_rd) begin
                rdata_q <= fl_rdata;
            end
        end
    end

    assign err   = err_q;
    assign rdata = rdata_q;

endmodule

// File: rtl/fcs_checker.sv
module fcs_checker #(
    parameter int unsigned AW       = 8,
    parameter int unsigned DW       = 16,
    parameter int unsigned MIN_CYC  = 18,
    parameter int unsigned MAX_CYC  = 85,
    parameter int unsigned HOLD_CYC = 18
) (
    input logic          clk,
    input logic          rst_n,
    input logic          fl_read_n,
    input logic          fl_write_n,
    input logic          fl_erase_n,
    input logic [AW-1:0] fl_addr,
    input logic [DW-1:0] fl_wdata,
    input logic          fl_busy_n,
    input logic          ready,
    input logic          done,
    input logic          err
);

    logic        low_now;
    logic        prev_low;
    logic [31:0] low_cnt;
    logic [31:0] fall_cnt;

    assign low_now = !(fl_read_n && fl_write_n && fl_erase_n);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_low <= 1'b0;
            low_cnt  <= '0;
            fall_cnt <= '0;
        end else begin
            prev_low <= low_now;
            low_cnt  <= low_now ? low_cnt + 32'd1 : 32'd0;
            if (low_now && !prev_low) begin
                fall_cnt <= 32'd1;
            end else if ((fall_cnt != 0) && (fall_cnt < HOLD_CYC)) begin
                fall_cnt <= fall_cnt + 32'd1;
            end else begin
                fall_cnt <= '0;
            end
        end
    end

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({~fl_read_n, ~fl_write_n, ~fl_erase_n}) <= 1); // R2

    AST_WIDTH_BELOW_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        low_now |-> (low_cnt < MAX_CYC)); // R3

    AST_SHORT_PULSE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (!low_now && (low_cnt != 0) && (low_cnt < MIN_CYC)) |-> err); // R4

    AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_cnt != 0) |-> ($stable(fl_addr) && $stable(fl_wdata))); // R5

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6

    AST_DONE_AFTER_BUSY_HI: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(fl_busy_n)); // R6

    AST_READY_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> !low_now); // R8

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err); // R9

endmodule

bind flash_cmd_seq fcs_checker #(
    .AW       (AW),
    .DW       (DW),
    .MIN_CYC  (MIN_CYC),
    .MAX_CYC  (MAX_CYC),
    .HOLD_CYC (HOLD_CYC)
) u_fcs_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fl_read_n  (fl_read_n),
    .fl_write_n (fl_write_n),
    .fl_erase_n (fl_erase_n),
    .fl_addr    (fl_addr),
    .fl_wdata   (fl_wdata),
    .fl_busy_n  (fl_busy_n),
    .ready      (ready),
    .done       (done),
    .err        (err)
);

// File: tb/test_flash_cmd_seq.sv
module test_flash_cmd_seq;

    localparam int CLK_PERIOD = 10;
    localparam int DUT_CLK_NS = 35;
    localparam int AW = 8;
    localparam int DW = 16;
    // R10: ceil(600/35)=18, floor(3000/35)=85, floor(300/35)=8, ceil(600/35)=18
    localparam int EXP_MIN  = 18;
    localparam int EXP_MAX  = 85;
    localparam int EXP_DL   = 8;
    localparam int EXP_HOLD = 18;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [1:0]    req_op = 2'd3;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          ready, done, err;
    logic [DW-1:0] rdata;
    logic          fl_read_n, fl_write_n, fl_erase_n;
    logic [AW-1:0] fl_addr;
    logic [DW-1:0] fl_wdata;
    logic [DW-1:0] fl_rdata = '0;
    logic          fl_busy_n = 1'b1;

    flash_cmd_seq #(
        .CLK_NS (DUT_CLK_NS),
        .AW     (AW),
        .DW     (DW)
    ) i_flash_cmd_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_op     (req_op),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .ready      (ready),
        .done       (done),
        .rdata      (rdata),
        .err        (err),
        .fl_read_n  (fl_read_n),
        .fl_write_n (fl_write_n),
        .fl_erase_n (fl_erase_n),
        .fl_addr    (fl_addr),
        .fl_wdata   (fl_wdata),
        .fl_rdata   (fl_rdata),
        .fl_busy_n  (fl_busy_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] pattern(input logic [AW-1:0] a);
        return {a, a} ^ 16'h5A5A;
    endfunction

    // ---------------- array model (acts on falling edges) ----------------
    int fm_lat = 1;
    int fm_hold = 1;
    int fm_low = 0;
    int fm_rel = 0;
    int wlow = 0;
    int last_width = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!(fl_read_n && fl_write_n && fl_erase_n)) begin
                fm_low++;
                fm_rel = 0;
                if (fm_low == fm_lat) fl_busy_n = 1'b0;
                wlow++;
            end else begin
                fm_low = 0;
                if (!fl_busy_n) begin
                    fm_rel++;
                    if (fm_rel >= fm_hold) fl_busy_n = 1'b1;
                end
                if (wlow != 0) begin
                    last_width = wlow;
                    wlow = 0;
                end
            end
            fl_rdata = fl_busy_n ? pattern(fl_addr) : 16'hDEAD;
        end
    end

    // ---------------- reference model (acts on rising edges) -------------
    int          m_ph = 0;   // 0 idle, 1 low, 2 drain, 3 done, 4 guard
    int          m_n = 0;
    bit          m_seen = 0;
    bit          m_err = 0;
    int          m_op = 0;
    logic [AW-1:0] m_addr = '0;
    logic [DW-1:0] m_wd = '0;
    logic [DW-1:0] m_rd = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_n = 0; m_seen = 0; m_err = 0; m_op = 0;
            m_addr = '0; m_wd = '0; m_rd = '0;
        end else begin
            case (m_ph)
                0: if (req_valid && req_op != 2'd3) begin
                    m_op = int'(req_op); m_addr = req_addr; m_wd = req_wdata;
                    m_n = 0; m_seen = 0; m_ph = 1;
                end
                1: begin
                    m_n++;
                    if (!fl_busy_n) m_seen = 1;
                    if (!m_seen && m_n >= EXP_DL) begin
                        m_err = 1;
                        m_ph = (m_n >= EXP_HOLD) ? 3 : 4;
                    end else if (m_seen && m_n >= EXP_MIN) m_ph = 2;
                    else if (m_n >= EXP_MAX) m_ph = 2;
                end
                2: begin
                    m_n++;
                    if (fl_busy_n && m_n >= EXP_HOLD) begin
                        if (m_op == 0) m_rd = fl_rdata;
                        m_ph = 3;
                    end
                end
                4: begin
                    m_n++;
                    if (m_n >= EXP_HOLD) m_ph = 3;
                end
                default: m_ph = 0;
            endcase
        end
    end

    // ---------------- per-cycle comparison ----------------
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R8 ready", ready, m_ph == 0);
            chk("R6 done", done, m_ph == 3);
            chk("R2 read strobe", fl_read_n, !(m_ph == 1 && m_op == 0));
            chk("R2 write strobe", fl_write_n, !(m_ph == 1 && m_op == 1));
            chk("R2 erase strobe", fl_erase_n, !(m_ph == 1 && m_op == 2));
            chk("R5 addr bus", fl_addr, m_addr);
            chk("R5 wdata bus", fl_wdata, m_wd);
            chk("R7 rdata", rdata, m_rd);
            chk("R4 err", err, m_err);
        end
    end

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic run_op(input logic [1:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input int lat, input int hold, input bit poke, input string tag);
        int waited;
        bit got;
        @(negedge clk);
        fm_lat = lat; fm_hold = hold;
        req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        waited = 0;
        got = 0;
        while (!got && waited < 1000) begin
            @(negedge clk);
            waited++;
            if (done) got = 1;
            if (poke && !got && waited >= 3 && waited <= 5) begin
                req_valid = 1'b1; req_op = 2'd1; req_addr = ~a; req_wdata = ~d;
            end else begin
                req_valid = 1'b0;
            end
        end
        req_valid = 1'b0;
        chk({tag, " done seen"}, got, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 read_n", fl_read_n, 1'b1);
        chk("R1 write_n", fl_write_n, 1'b1);
        chk("R1 erase_n", fl_erase_n, 1'b1);
        chk("R1 ready", ready, 1'b1);
        chk("R1 done", done, 1'b0);
        chk("R1 err", err, 1'b0);
        chk("R1 rdata", rdata, 16'h0);
        rst_n = 1'b1;

        // R7 normal read, capture after busy high
        run_op(2'd0, 8'h3C, 16'h0000, 3, 2, 1'b0, "R7");
        chk("R7 read value", rdata, pattern(8'h3C));
        chk("R3 width read", last_width, EXP_MIN);
        chk("R10 min cycles", last_width, 18);

        // R2 write, busy at deadline edge (no error), R4 boundary
        run_op(2'd1, 8'h81, 16'hBEEF, EXP_DL, 1, 1'b0, "R2");
        chk("R4 boundary no err", err, 1'b0);
        chk("R7 rdata kept after write", rdata, pattern(8'h3C));

        // R8 erase with extra requests during the sequence
        run_op(2'd2, 8'h55, 16'h1234, 1, 5, 1'b1, "R8");
        chk("R8 addr kept", fl_addr, 8'h55);
        chk("R3 width erase", last_width, EXP_MIN);

        // R2 reserved code ignored
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'd3; req_addr = 8'hF0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R2 reserved ready", ready, 1'b1);
            chk("R2 reserved strobes", {fl_read_n, fl_write_n, fl_erase_n}, 3'b111);
        end
        req_valid = 1'b0;

        // R4 timeout: busy falls one cycle too late
        run_op(2'd0, 8'h11, 16'h0, EXP_DL + 1, 1, 1'b0, "R4");
        chk("R4 err set", err, 1'b1);
        chk("R4 width", last_width, EXP_DL);
        chk("R10 deadline cycles", last_width, 8);
        chk("R7 rdata kept on timeout", rdata, pattern(8'h3C));

        // R9 err stays, next op still works
        run_op(2'd0, 8'h99, 16'h0, 2, 3, 1'b0, "R9");
        chk("R9 err sticky", err, 1'b1);
        chk("R9 read after error", rdata, pattern(8'h99));

        // R5 timeout with busy never falling, guard holds bus
        run_op(2'd1, 8'h42, 16'hCAFE, -1, 1, 1'b0, "R5");
        chk("R5 timeout width", last_width, EXP_DL);

        // R6 long busy tail
        run_op(2'd0, 8'h07, 16'h0, 4, 40, 1'b0, "R6");
        chk("R6 long read value", rdata, pattern(8'h07));

        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule